// File: doc/BRIEF.md
# Four-Function ALU with Flags

This block is a purely combinational arithmetic logic unit. It takes two N-bit operands and a 3-bit operation select. It returns a result word along with three flags: zero, carry-out and signed overflow. The four operations are bitwise AND, bitwise OR, addition and subtraction. Subtraction adds the one's complement of the second operand to the first and injects the extra one through the adder's carry-in, so no second adder is needed.

The select code is arranged so that its top bit alone drives both the operand inversion and the adder carry-in. Add (010) and subtract (110) therefore differ only in that bit. The adder is a ripple-carry chain. The operand width is a parameter, 32 by default, and must be at least 4. Outputs have no register stage, so a surrounding pipeline places the block between its own flops.

Top module: `quad_alu`

## Requirements
- R1: Select 000 makes the result the bitwise AND of A and B.
- R2: Select 001 makes the result the bitwise OR of A and B.
- R3: Select 010 makes the result (A + B) modulo 2^W.
- R4: Select 110 makes the result (A - B) modulo 2^W, computed as A + ~B with adder carry-in 1.
- R5: For 010 the carry flag is the carry out of the top bit. For 110 the carry flag is the raw adder carry, so it is 1 when A >= B unsigned (no borrow) and 0 otherwise.
- R6: For every select code, the zero flag is 1 exactly when all result bits are 0.
- R7: For 010 and 110 the overflow flag is 1 exactly when the carry into the top bit differs from the carry out of it. That is the same as a two's-complement signed overflow of the operation.
- R8: For 000 and 001 the carry and overflow flags are both 0.
- R9: The unlisted codes 011, 100, 101 and 111 give a result of all zeros, zero flag 1, and carry and overflow 0.
- R10: All outputs are a combinational function of the present inputs, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 3 | Operation select (000 AND, 001 OR, 010 add, 110 subtract) |
| result | output | W | Operation result |
| zero_flag | output | 1 | 1 when every result bit is 0 |
| carry_flag | output | 1 | Adder carry-out for add/subtract, 0 otherwise |
| ovf_flag | output | 1 | Signed overflow for add/subtract, 0 otherwise |

## Verification
Each time the inputs change, the embedded assertions compare the ripple sum against native arithmetic for add and subtract. They also check that subtract drives the inverted operand and a carry-in of one, that logical operations clear both arithmetic flags, and that unlisted codes give the all-zero result. The bench's directed operands are what bring out the exact carry and overflow boundaries: the largest positive value plus one, the most negative value minus one, equal operands and borrow cases. The bench also shows the zero flag against its reference model on every code. Many random operand and select mixes confirm that the outputs follow the inputs with no clock involved.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and result-select types for quad_alu.
// Assumes the top select bit means "invert B and carry in one".
package alu_pkg;

    localparam int ALU_MIN_W = 4;

    typedef enum logic [2:0] {
        OPC_AND = 3'b000,
        OPC_OR  = 3'b001,
        OPC_ADD = 3'b010,
        OPC_SUB = 3'b110
    } alu_opc_e;

    typedef enum logic [1:0] {
        RSEL_AND  = 2'd0,
        RSEL_OR   = 2'd1,
        RSEL_SUM  = 2'd2,
        RSEL_NONE = 2'd3
    } alu_rsel_e;

endpackage

// File: rtl/alu_opdec.sv
// Module: alu_opdec
// Decodes the 3-bit select into datapath controls. The top select bit feeds
// the operand inversion and adder carry-in directly. Assumes nothing about
// which codes are legal: unlisted codes decode to RSEL_NONE.
module alu_opdec
    import alu_pkg::*;
(
    input  logic [2:0] op_sel,
    output logic       inv_b,
    output logic       add_cin,
    output logic       arith,
    output alu_rsel_e  rsel
);

    // Top bit shared by operand inversion and carry-in.
    assign inv_b   = op_sel[2];
    assign add_cin = op_sel[2];

    // Map each code onto a result source; unlisted codes pick nothing.
    always_comb begin
        unique case (op_sel)
            OPC_AND: rsel = RSEL_AND;
            OPC_OR:  rsel = RSEL_OR;
            OPC_ADD: rsel = RSEL_SUM;
            OPC_SUB: rsel = RSEL_SUM;
            default: rsel = RSEL_NONE;
        endcase
    end

    // Arithmetic flags only apply when the sum is selected.
    assign arith = (rsel == RSEL_SUM);

endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Per-bit AND and OR lanes, built with generate. Assumes W >= 1.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);

    // One gate pair per bit position.
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign and_o[i] = a[i] & b[i];
        assign or_o[i]  = a[i] | b[i];
    end

endmodule

// File: rtl/alu_ripple.sv
// Module: alu_ripple
// Ripple-carry adder. Besides the sum and the final carry it exports the carry
// into the top bit, which the overflow logic uses. Assumes W >= 2.
module alu_ripple #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_into_msb
);

    // Walk the carry from bit 0 to bit W-1 in one process to keep it acyclic.
    always_comb begin
        logic c;
        c          = cin;
        c_into_msb = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == W - 1) c_into_msb = c;
            sum[i] = a[i] ^ b[i] ^ c;
            c      = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
        end
        cout = c;
    end

endmodule

// File: rtl/quad_alu.sv
// Module: quad_alu (top)
// Combinational four-function ALU with zero, carry and signed-overflow flags.
// Assumes W >= ALU_MIN_W. No clock or reset: the caller registers outputs.
module quad_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         zero_flag,
    output logic         carry_flag,
    output logic         ovf_flag
);

    localparam int MSB = W - 1;

    if (W < ALU_MIN_W) begin : g_width_chk
        $error("quad_alu: W below minimum");
    end

    logic          inv_b, add_cin, arith;
    alu_rsel_e     rsel;
    logic [W-1:0]  b_eff, and_v, or_v, sum_v;
    logic          cout_v, cmsb_v;

    alu_opdec u_dec (
        .op_sel  (op_sel),
        .inv_b   (inv_b),
        .add_cin (add_cin),
        .arith   (arith),
        .rsel    (rsel)
    );

    alu_logic #(.W(W)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .and_o (and_v),
        .or_o  (or_v)
    );

    // Conditionally invert B for subtraction.
    assign b_eff = inv_b ? ~opnd_b : opnd_b;

    alu_ripple #(.W(W)) u_add (
        .a          (opnd_a),
        .b          (b_eff),
        .cin        (add_cin),
        .sum        (sum_v),
        .cout       (cout_v),
        .c_into_msb (cmsb_v)
    );

    // Result multiplexer.
    always_comb begin
        unique case (rsel)
            RSEL_AND: result = and_v;
            RSEL_OR:  result = or_v;
            RSEL_SUM: result = sum_v;
            default:  result = '0;
        endcase
    end

    // Flags: wide NOR for zero, arithmetic flags gated by the decode.
    assign zero_flag  = ~|result;
    assign carry_flag = arith & cout_v;
    assign ovf_flag   = arith & (cout_v ^ cmsb_v);

    // Datapath checks, evaluated whenever the inputs change.
    always_comb begin
        logic [W:0] ref_sum;
        logic [W:0] ref_dif;
        ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
        ref_dif = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{W{1'b0}}, 1'b1};
        if (op_sel == OPC_ADD)
            AST_ADD_SUM: assert ({carry_flag, result} == ref_sum); // R3
        if (op_sel == OPC_SUB)
            AST_SUB_DIFF: assert ({carry_flag, result} == ref_dif); // R4
        if (op_sel == OPC_SUB)
            AST_SUB_CIN: assert (add_cin && (b_eff == ~opnd_b)); // R4
        if (op_sel == OPC_ADD)
            AST_ADD_OVF: assert (ovf_flag == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))); // R7
        if (op_sel == OPC_AND || op_sel == OPC_OR)
            AST_LOGIC_FLAGS: assert (!carry_flag && !ovf_flag); // R8
        if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101 || op_sel == 3'b111)
            AST_UNLISTED: assert (result == '0 && zero_flag && !carry_flag && !ovf_flag); // R9
    end

endmodule

// File: tb/quad_alu_tb.sv
// Bench for quad_alu: directed corners plus seeded random mix, each output
// compared with a behavioural model written from the requirements.
module quad_alu_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         zf, cf, vf;
    int           n_run  = 0;
    int           n_fail = 0;

    always #5 clk = ~clk;

    quad_alu #(.W(W)) u_dut (
        .opnd_a     (a),
        .opnd_b     (b),
        .op_sel     (op),
        .result     (res),
        .zero_flag  (zf),
        .carry_flag (cf),
        .ovf_flag   (vf)
    );

    // Reference model: returns {carry, ovf, result}.
    function automatic logic [W+1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [2:0] o);
        logic [W:0]   s;
        logic         v;
        logic [W-1:0] r;
        case (o)
            3'b000: return {2'b00, x & y};
            3'b001: return {2'b00, x | y};
            3'b010: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[W-1:0];
                v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
                return {s[W], v, r};
            end
            3'b110: begin
                s = {1'b0, x} + {1'b0, ~y} + 1;
                r = s[W-1:0];
                v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
                return {s[W], v, r};
            end
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h op=%b)", tag, act, exp, a, b, op);
        end
    endtask

    // Drive away from the edge, let logic settle, compare all outputs.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o);
        logic [W+1:0] m;
        string rtag;
        @(negedge clk);
        a = x; b = y; op = o;
        #2;
        m = model(x, y, o);
        case (o)
            3'b000:  rtag = "R1";
            3'b001:  rtag = "R2";
            3'b010:  rtag = "R3";
            3'b110:  rtag = "R4";
            default: rtag = "R9";
        endcase
        check(rtag, 64'(res), 64'(m[W-1:0]));
        check("R6 zero", 64'(zf), 64'(m[W-1:0] == '0));
        check((o == 3'b010 || o == 3'b110) ? "R5 carry" : "R8/R9 carry", 64'(cf), 64'(m[W+1]));
        check((o == 3'b010 || o == 3'b110) ? "R7 ovf" : "R8/R9 ovf", 64'(vf), 64'(m[W]));
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [2:0] codes [8];
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        a = '0; b = '0; op = 3'b000;
        // Initial state: all-zero inputs give zero result, zero flag set
        apply('0, '0, 3'b000);
        // R1 / R2 directed patterns
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'b000);
        apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b000);
        apply(32'h1234_0000, 32'h0000_5678, 3'b001);
        apply(32'h0000_0000, 32'h0000_0000, 3'b001);
        // R3 / R5 / R7 add corners
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
        apply(32'h8000_0000, 32'h8000_0000, 3'b010);
        apply(32'h0000_0003, 32'h0000_0004, 3'b010);
        // R4 / R5 / R7 subtract corners
        apply(32'h0000_0005, 32'h0000_0005, 3'b110);
        apply(32'h0000_0000, 32'h0000_0001, 3'b110);
        apply(32'h8000_0000, 32'h0000_0001, 3'b110);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
        apply(32'h0000_0000, 32'h0000_0000, 3'b110);
        // R9 unlisted codes with nonzero operands
        apply(32'hDEAD_BEEF, 32'h0123_4567, 3'b011);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);
        apply(32'h8000_0000, 32'h8000_0000, 3'b101);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b111);
        // R10: inputs change twice within one clock period, outputs track
        @(negedge clk);
        a = 32'd10; b = 32'd3; op = 3'b010;
        #1 check("R10 comb", 64'(res), 64'd13);
        op = 3'b110;
        #1 check("R10 comb", 64'(res), 64'd7);
        // Constrained random: mostly legal codes, some unlisted
        codes = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b010, 3'b110, 3'b011, 3'b101};
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] x, y;
            x = $urandom;
            y = ($urandom_range(0, 7) == 0) ? x : W'($urandom);
            if ($urandom_range(0, 15) == 0) x = {1'b1, {(W-1){1'b0}}};
            apply(x, y, codes[$urandom_range(0, 7)]);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule